// File: doc/BRIEF.md
# Filtered Asynchronous Serial Receiver

This block is the receive half of an asynchronous serial port. It samples the incoming line on every pulse of a 16x oversampling tick supplied from outside. An optional three-sample majority vote can remove single-sample glitches before the line reaches the frame recogniser.

The recogniser waits for a falling edge and confirms the start bit at its middle. It then collects eight data bits, least significant first, optionally checks a parity bit, and samples the stop bit. Each finished character is placed in a holding register and a ready flag is raised.

Overrun, framing and parity problems are kept as sticky flags until a clear pulse arrives. Single-cycle command pulses switch the receiver on and off and abort any frame in progress.

Top module: `serial_rx_filtered`

## Requirements
- R1: After reset the receiver is disabled, the ready flag and all three error flags are 0, and the held byte is 0x00.
- R2: An enable pulse turns the receiver on and a disable pulse turns it off. When both arrive in the same cycle the receiver ends up off. While off, the recogniser stays idle and no character is delivered.
- R3: A frame begins only on a high-to-low transition of the effective line that is still low 8 ticks later (mid start bit). If the line is high at that point, the recogniser returns to idle without delivering anything.
- R4: Data bits are sampled every 16 ticks after the confirmed start, LSB first. On completion the byte appears on `rx_data` and `rx_ready` rises.
- R5: `par_mode` selects the parity scheme: 0 even, 1 odd, 2 parity bit must be 0, 3 parity bit must be 1, 4 to 7 no parity bit in the frame. A parity bit that does not match the scheme sets `err_parity`.
- R6: A stop bit sampled low sets `err_frame`. The character is still stored and `rx_ready` still rises.
- R7: A character that completes while `rx_ready` is 1, with no read in that same cycle, sets `err_overrun`. The new byte replaces the old one. A read in the completion cycle avoids the overrun.
- R8: A `rd_ack` pulse, with no character completing in that cycle, clears `rx_ready` on the next clock.
- R9: A `cmd_clr_err` pulse clears all three error flags.
- R10: With `filt_en` = 1 the effective line is the 2-of-3 majority of the last three tick samples, so a one-tick inversion of the line has no effect. With `filt_en` = 0 the latest sample is used directly.
- R11: A `cmd_rx_reset` pulse aborts any frame in progress and clears `rx_ready`. The enable state and the error flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | One-cycle pulse, 16 per bit time |
| line_in | input | 1 | Serial receive line, idle high |
| filt_en | input | 1 | 1 selects the majority filter |
| par_mode | input | 3 | Parity scheme code (see R5) |
| cmd_enable | input | 1 | Turn receiver on |
| cmd_disable | input | 1 | Turn receiver off (wins over enable) |
| cmd_rx_reset | input | 1 | Abort frame, clear ready flag |
| cmd_clr_err | input | 1 | Clear the sticky error flags |
| rd_ack | input | 1 | Holding register has been read |
| rx_data | output | 8 | Last received byte |
| rx_ready | output | 1 | Unread character present |
| err_overrun | output | 1 | Sticky overrun flag |
| err_frame | output | 1 | Sticky framing error flag |
| err_parity | output | 1 | Sticky parity error flag |
| rx_enabled | output | 1 | Receiver on |

## Verification
A character completing and a host read can fall in the same clock. The outcome of that collision decides whether an overrun is reported.

The bench provokes it on purpose. It leaves one character unread, then watches its own reference model and raises `rd_ack` in exactly the cycle the next stop bit is sampled. It judges that no overrun appears, `rx_ready` stays 1 and the new byte is held.

The enable and disable pulses also collide in one cycle. That case is judged by the resulting enable state.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] data;
        logic              frm_err;
        logic              par_err;
    } rx_char_t;

    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic logic has_parity(input logic [2:0] mode);
        return mode < 3'd4;
    endfunction

    function automatic logic parity_ok(input logic [2:0] mode,
                                       input logic [CHAR_W-1:0] d,
                                       input logic p);
        case (mode)
            3'd0:    return (^{d, p}) == 1'b0;
            3'd1:    return (^{d, p}) == 1'b1;
            3'd2:    return p == 1'b0;
            3'd3:    return p == 1'b1;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/rx_sampler.sv
module rx_sampler
    import serial_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line_in,
    input  logic filt_en,
    output logic line_eff,
    output logic line_prev
);
    logic [2:0] hist;

    assign line_eff = filt_en ? maj3(hist) : hist[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            hist      <= 3'b111;
            line_prev <= 1'b1;
        end else if (tick) begin
            hist      <= {hist[1:0], line_in};
            line_prev <= line_eff;
        end
    end
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import serial_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       en,
    input  logic       abort,
    input  logic [2:0] par_mode,
    input  logic       line_eff,
    input  logic       line_prev,
    output rx_char_t   chr
);
    localparam int CW  = $clog2(OVS);
    localparam int IW  = $clog2(CHAR_W);
    localparam int MID = OVS / 2;

    rx_state_e         st;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     idx;
    logic [CHAR_W-1:0] sh;
    logic              pe;
    logic              at_end;

    assign at_end      = (cnt == CW'(OVS - 1));
    assign chr.valid   = tick && en && !abort && (st == ST_STOP) && at_end;
    assign chr.data    = sh;
    assign chr.frm_err = !line_eff;
    assign chr.par_err = pe;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
            idx <= '0;
            sh  <= '0;
            pe  <= 1'b0;
        end else if (abort || !en) begin
            st  <= ST_IDLE;
            cnt <= '0;
            idx <= '0;
        end else if (tick) begin
            case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (line_prev && !line_eff) st <= ST_START;
                end
                ST_START: begin
                    if (cnt == CW'(MID - 1)) begin
                        cnt <= '0;
                        idx <= '0;
                        pe  <= 1'b0;
                        st  <= line_eff ? ST_IDLE : ST_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (at_end) begin
                        cnt <= '0;
                        sh  <= {line_eff, sh[CHAR_W-1:1]};
                        if (idx == IW'(CHAR_W - 1))
                            st <= has_parity(par_mode) ? ST_PAR : ST_STOP;
                        else
                            idx <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (at_end) begin
                        cnt <= '0;
                        pe  <= !parity_ok(par_mode, sh, line_eff);
                        st  <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (at_end) begin
                        cnt <= '0;
                        st  <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R2: a disabled receiver holds the recogniser idle
    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st == ST_IDLE));

    // R11: an abort returns the recogniser to idle
    a_r11_abort_idle: assert property (@(posedge clk) disable iff (rst)
        abort |=> (st == ST_IDLE));
endmodule

// File: rtl/rx_holding.sv
module rx_holding
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              rd_ack,
    input  logic              clr_err,
    input  rx_char_t          chr,
    output logic [CHAR_W-1:0] data,
    output logic              ready,
    output logic              ovr,
    output logic              frm,
    output logic              par
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            ready <= 1'b0;
            ovr   <= 1'b0;
            frm   <= 1'b0;
            par   <= 1'b0;
        end else begin
            if (chr.valid) data <= chr.data;
            if (abort)          ready <= 1'b0;
            else if (chr.valid) ready <= 1'b1;
            else if (rd_ack)    ready <= 1'b0;
            ovr <= (ovr & ~clr_err) | (chr.valid & ready & ~rd_ack);
            frm <= (frm & ~clr_err) | (chr.valid & chr.frm_err);
            par <= (par & ~clr_err) | (chr.valid & chr.par_err);
        end
    end

    a_r4_ready_after_char: assert property (@(posedge clk) disable iff (rst)
        (chr.valid && !abort) |=> ready);

    a_r7_overrun_needs_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(ready));

    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !chr.valid) |=> !ready);

    a_r9_clear_flags: assert property (@(posedge clk) disable iff (rst)
        (clr_err && !chr.valid) |=> !(ovr || frm || par));
endmodule

// File: rtl/serial_rx_filtered.sv
module serial_rx_filtered
    import serial_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_16x,
    input  logic       line_in,
    input  logic       filt_en,
    input  logic [2:0] par_mode,
    input  logic       cmd_enable,
    input  logic       cmd_disable,
    input  logic       cmd_rx_reset,
    input  logic       cmd_clr_err,
    input  logic       rd_ack,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       err_overrun,
    output logic       err_frame,
    output logic       err_parity,
    output logic       rx_enabled
);
    logic     line_eff;
    logic     line_prev;
    rx_char_t chr;

    always_ff @(posedge clk) begin
        if (rst)              rx_enabled <= 1'b0;
        else if (cmd_disable) rx_enabled <= 1'b0;
        else if (cmd_enable)  rx_enabled <= 1'b1;
    end

    rx_sampler u_samp (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_16x),
        .line_in  (line_in),
        .filt_en  (filt_en),
        .line_eff (line_eff),
        .line_prev(line_prev)
    );

    rx_framer #(.OVS(OVS)) u_frm (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_16x),
        .en       (rx_enabled),
        .abort    (cmd_rx_reset),
        .par_mode (par_mode),
        .line_eff (line_eff),
        .line_prev(line_prev),
        .chr      (chr)
    );

    rx_holding u_hold (
        .clk    (clk),
        .rst    (rst),
        .abort  (cmd_rx_reset),
        .rd_ack (rd_ack),
        .clr_err(cmd_clr_err),
        .chr    (chr),
        .data   (rx_data),
        .ready  (rx_ready),
        .ovr    (err_overrun),
        .frm    (err_frame),
        .par    (err_parity)
    );

    a_r2_disable_wins: assert property (@(posedge clk) disable iff (rst)
        (cmd_enable && cmd_disable) |=> !rx_enabled);
endmodule

// File: tb/tb_serial_rx_filtered.sv
`timescale 1ns/1ps
module tb_serial_rx_filtered;
    localparam int TDIV = 4;
    localparam int OVS  = 16;

    logic clk = 0;
    logic rst = 1;
    logic tick_16x = 0;
    logic line_in = 1;
    logic filt_en = 0;
    logic [2:0] par_mode = 3'd4;
    logic cmd_enable = 0, cmd_disable = 0, cmd_rx_reset = 0, cmd_clr_err = 0;
    logic rd_man = 0, rd_auto = 0;
    logic arm_rd = 0;
    wire  rd_ack = rd_man | rd_auto;
    logic [7:0] rx_data;
    logic rx_ready, err_overrun, err_frame, err_parity, rx_enabled;

    int n_cmp = 0, n_bad = 0, tcnt = 0;

    always #5 clk = ~clk;

    serial_rx_filtered #(.OVS(OVS)) dut (
        .clk(clk), .rst(rst), .tick_16x(tick_16x), .line_in(line_in),
        .filt_en(filt_en), .par_mode(par_mode), .cmd_enable(cmd_enable),
        .cmd_disable(cmd_disable), .cmd_rx_reset(cmd_rx_reset),
        .cmd_clr_err(cmd_clr_err), .rd_ack(rd_ack), .rx_data(rx_data),
        .rx_ready(rx_ready), .err_overrun(err_overrun), .err_frame(err_frame),
        .err_parity(err_parity), .rx_enabled(rx_enabled)
    );

    // ---------------- behavioural reference ----------------
    bit [2:0] m_s = 3'b111;
    bit m_prev = 1, m_on = 0, m_rdy = 0, m_ovr = 0, m_frm = 0, m_par = 0, m_pe = 0;
    int m_st = 0, m_cnt = 0, m_bit = 0;
    bit [7:0] m_sh = 0, m_data = 0;

    function automatic bit exp_par(input bit [2:0] mode, input bit [7:0] d);
        case (mode)
            3'd0: return ($countones(d) % 2) == 1;
            3'd1: return ($countones(d) % 2) == 0;
            3'd2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    always @(posedge clk) begin
        bit eff, done, d_fe, d_pe;
        bit [7:0] d_val;
        if (rst) begin
            m_s = 3'b111; m_prev = 1; m_on = 0; m_rdy = 0; m_ovr = 0;
            m_frm = 0; m_par = 0; m_pe = 0; m_st = 0; m_cnt = 0; m_bit = 0;
            m_sh = 0; m_data = 0;
        end else begin
            eff  = filt_en ? ($countones(m_s) >= 2) : m_s[0];
            done = 0; d_fe = 0; d_pe = 0; d_val = 0;
            if (cmd_rx_reset || !m_on) begin
                m_st = 0; m_cnt = 0; m_bit = 0;
            end else if (tick_16x) begin
                if (m_st == 0) begin
                    m_cnt = 0;
                    if (m_prev && !eff) m_st = 1;
                end else if (m_st == 1) begin
                    if (m_cnt == OVS/2 - 1) begin
                        m_cnt = 0; m_bit = 0; m_pe = 0;
                        m_st = eff ? 0 : 2;
                    end else m_cnt++;
                end else if (m_cnt == OVS - 1) begin
                    m_cnt = 0;
                    if (m_st == 2) begin
                        m_sh[m_bit] = eff;
                        if (m_bit == 7) m_st = (par_mode < 4) ? 3 : 4;
                        else m_bit++;
                    end else if (m_st == 3) begin
                        m_pe = (eff != exp_par(par_mode, m_sh));
                        m_st = 4;
                    end else begin
                        done = 1; d_val = m_sh; d_fe = !eff; d_pe = m_pe;
                        m_st = 0;
                    end
                end else m_cnt++;
            end
            if (tick_16x) begin
                m_prev = eff;
                m_s = {m_s[1:0], line_in};
            end
            m_ovr = (m_ovr && !cmd_clr_err) || (done && m_rdy && !rd_ack);
            m_frm = (m_frm && !cmd_clr_err) || (done && d_fe);
            m_par = (m_par && !cmd_clr_err) || (done && d_pe);
            if (done) m_data = d_val;
            if (cmd_rx_reset) m_rdy = 0;
            else if (done) m_rdy = 1;
            else if (rd_ack) m_rdy = 0;
            if (cmd_disable) m_on = 0;
            else if (cmd_enable) m_on = 1;
        end
    end

    // tick generator and read timed onto a completing character (R7)
    always @(negedge clk) begin
        tcnt = (tcnt + 1) % TDIV;
        tick_16x = (tcnt == 0);
        rd_auto = 0;
        if (arm_rd && tick_16x && m_on && m_st == 4 && m_cnt == OVS - 1) begin
            rd_auto = 1;
            arm_rd  = 0;
        end
    end

    // per-cycle comparison
    task automatic cmp(input string req, input string nm, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            cmp("R4", "rx_data", rx_data, m_data);
            cmp("R4", "rx_ready", rx_ready, m_rdy);
            cmp("R7", "err_overrun", err_overrun, m_ovr);
            cmp("R6", "err_frame", err_frame, m_frm);
            cmp("R5", "err_parity", err_parity, m_par);
            cmp("R2", "rx_enabled", rx_enabled, m_on);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic hold(input bit v, input int nt);
        line_in = v;
        repeat (nt * TDIV) @(negedge clk);
    endtask

    task automatic send(input bit [7:0] d, input bit [2:0] mode, input bit bad_par,
                        input bit stop_v, input bit glitch);
        hold(0, 16);
        for (int i = 0; i < 8; i++) begin
            if (glitch) begin
                hold(d[i], 7); hold(!d[i], 1); hold(d[i], 8);
            end else hold(d[i], 16);
        end
        if (mode < 4) hold(exp_par(mode, d) ^ bad_par, 16);
        hold(stop_v, 16);
        hold(1, 6);
    endtask

    task automatic pulse(ref logic s);
        s = 1; @(negedge clk); s = 0; @(negedge clk);
    endtask

    task automatic pulse_rd();
        rd_man = 1; @(negedge clk); rd_man = 0; @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        cmp("R1", "rx_ready", rx_ready, 0);
        cmp("R1", "errors", {err_overrun, err_frame, err_parity}, 0);
        cmp("R1", "rx_enabled", rx_enabled, 0);
        cmp("R1", "rx_data", rx_data, 0);

        // R2 disabled receiver ignores a frame
        send(8'hA5, 3'd4, 0, 1, 0);
        cmp("R2", "ready while off", rx_ready, 0);

        // R2 simultaneous enable/disable: disable wins
        cmd_enable = 1; cmd_disable = 1; @(negedge clk);
        cmd_enable = 0; cmd_disable = 0; @(negedge clk);
        cmp("R2", "on+off", rx_enabled, 0);
        pulse(cmd_enable);
        cmp("R2", "enable", rx_enabled, 1);

        // R3 short low pulse: start not confirmed
        hold(1, 4); hold(0, 4); hold(1, 24);
        cmp("R3", "false start ready", rx_ready, 0);

        // R4 plain frame, R8 read clears
        send(8'h3C, 3'd4, 0, 1, 0);
        cmp("R4", "data 3C", rx_data, 8'h3C);
        cmp("R4", "ready", rx_ready, 1);
        pulse_rd();
        cmp("R8", "ready after read", rx_ready, 0);

        // R5 all parity schemes, good parity
        for (int m = 0; m < 4; m++) begin
            par_mode = 3'(m);
            send(8'h96 + 8'(m), 3'(m), 0, 1, 0);
            cmp("R5", "good parity data", rx_data, 8'h96 + m);
            cmp("R5", "good parity flag", err_parity, 0);
            pulse_rd();
        end
        par_mode = 3'd1;
        send(8'h81, 3'd1, 1, 1, 0);
        cmp("R5", "bad parity flag", err_parity, 1);
        cmp("R5", "bad parity data", rx_data, 8'h81);
        pulse_rd();
        par_mode = 3'd3;
        send(8'h00, 3'd3, 1, 1, 0);
        cmp("R5", "mark scheme violated", err_parity, 1);
        pulse_rd();

        // R9 clear errors
        pulse(cmd_clr_err);
        cmp("R9", "flags cleared", {err_overrun, err_frame, err_parity}, 0);

        // R6 framing error
        par_mode = 3'd4;
        send(8'h7E, 3'd4, 0, 0, 0);
        cmp("R6", "frame flag", err_frame, 1);
        cmp("R6", "data kept", rx_data, 8'h7E);
        cmp("R6", "ready", rx_ready, 1);

        // R7 overrun: second char while unread
        send(8'hC3, 3'd4, 0, 1, 0);
        cmp("R7", "overrun", err_overrun, 1);
        cmp("R7", "newest data", rx_data, 8'hC3);
        pulse(cmd_clr_err);

        // R7 read in the completion cycle avoids overrun
        arm_rd = 1;
        send(8'h5F, 3'd4, 0, 1, 0);
        cmp("R7", "no overrun on same-cycle read", err_overrun, 0);
        cmp("R7", "ready held", rx_ready, 1);
        cmp("R7", "data 5F", rx_data, 8'h5F);
        pulse_rd();

        // R10 filter removes one-tick glitches
        filt_en = 1;
        hold(1, 4); hold(0, 1); hold(1, 24);
        cmp("R10", "idle glitch", rx_ready, 0);
        send(8'h5A, 3'd4, 0, 1, 1);
        cmp("R10", "filtered data", rx_data, 8'h5A);
        cmp("R10", "no frame error", err_frame, 0);
        filt_en = 0;
        send(8'h69, 3'd4, 0, 1, 1);
        cmp("R10", "raw path still delivers", rx_ready, 1);

        // R11 abort mid-frame
        pulse(cmd_clr_err);
        send(8'h11, 3'd4, 0, 0, 0);
        hold(0, 40);
        pulse(cmd_rx_reset);
        hold(1, 200);
        cmp("R11", "ready cleared", rx_ready, 0);
        cmp("R11", "still enabled", rx_enabled, 1);
        cmp("R11", "error kept", err_frame, 1);

        // R2 disable stops reception
        pulse(cmd_disable);
        send(8'hEE, 3'd4, 0, 1, 0);
        cmp("R2", "off no char", rx_ready, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule